// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a four-bank, 16-bit synchronous DRAM from reset until the memory can accept normal traffic. After reset it keeps clock enable and the data masks high and drives a no-operation command. It holds this for a stabilisation interval given in microseconds and converted to clock cycles through a clock-frequency parameter. It then issues one precharge that covers every bank, a parameterised number of auto-refresh commands (at least two) and a mode register set. A parameter places the mode register set either before or after the refresh group.

Each command occupies exactly one clock cycle and is followed by a parameterised number of no-operation recovery cycles. The mode register value is packed from four plain configuration inputs: burst length code, burst ordering, CAS latency and the single-location-write option. Before that value is sent it is checked. A reserved combination is never written to the device: the sequencer stops, raises an error flag and keeps driving no-operation. A clean run ends with a sticky ready flag. A synchronous reset restarts the whole sequence at any point. The configuration inputs are plain level signals with no handshake and must be held stable until ready or the error flag rises.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and for the cycles before the precharge, clock enable and every data-mask bit are 1, the command {cs_n,ras_n,cas_n,we_n} is 0111 (no-operation), and ready and error are 0. The precharge appears on the W-th rising edge after reset falls, where W = CLK_MHZ*STABLE_US.
- R2: The first command is a precharge, 0010, with address bit 10 high and every other address and bank bit 0.
- R3: Exactly REF_COUNT auto-refresh commands (0001, address and bank 0) are issued, and each is followed by T_RFC no-operation cycles.
- R4: With MRS_FIRST=0 the mode register set (0000) comes after the last refresh recovery. With MRS_FIRST=1 it comes directly after the precharge recovery and before the first refresh.
- R5: The mode register set carries bank 0 and address bits: [2:0] burst length code, [3] burst ordering (0 sequential, 1 interleaved), [6:4] CAS latency, [8:7] zero, [9] single-location write, [12:10] zero.
- R6: The precharge is followed by T_RP no-operation cycles and the mode register set by T_MRD no-operation cycles.
- R7: Ready rises in the cycle after the last recovery interval ends. It then stays high, with the command held at no-operation, until reset.
- R8: A CAS latency other than 2 or 3, or a burst length code of 4, 5 or 6, is reserved. When the sequence reaches the mode register step with such a setting, no mode register set is issued, the error flag rises in that cycle and stays high, ready stays low, and only no-operation follows.
- R9: Burst length code 7 (full page, 512 columns) is legal with sequential ordering and reserved with interleaved ordering, which is handled as in R8.
- R10: Reset taken in the middle of the sequence restarts it from the stabilisation wait.
- R11: Every non-no-operation command lasts one cycle and is followed by at least one no-operation cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_burst_len | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| cfg_burst_ilv | input | 1 | Burst ordering, 1 = interleaved |
| cfg_cas_lat | input | 3 | CAS latency in cycles (2 or 3) |
| cfg_single_wr | input | 1 | Burst read with single-location write |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | DQM_W | Data masks |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | 2 | Bank address |
| init_ready | output | 1 | Initialization complete |
| cfg_error | output | 1 | Reserved configuration refused |

## Verification
The assertions check the following properties on every cycle:
- clock enable and the masks stay high;
- every precharge targets all banks;
- each command lasts one cycle before a no-operation;
- every mode register set has zero reserved fields and a legal latency and burst code, and never pairs full page with interleaving;
- ready and the error flag are sticky, mutually exclusive and quiet on the command pins.

Only the bench's cycle-by-cycle reference can show the exact stabilisation length, the recovery gap counts, the number of refreshes, and which order the parameter selects. The same holds for correct packing of each field value and for a clean restart after reset in mid-sequence.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command encoding on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_STABLE,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_GAP,
    ST_DONE,
    ST_HALT
  } init_state_e;

  localparam int BANK_W     = 2;
  localparam int MODE_BITS  = 13;
  localparam int AP_BIT     = 10;

  typedef struct packed {
    logic [2:0] burst_len;
    logic       burst_ilv;
    logic [2:0] cas_lat;
    logic       single_wr;
  } mode_cfg_t;

endpackage

// File: rtl/sdram_mode_word.sv
module sdram_mode_word
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  mode_cfg_t         cfg,
  output logic [ADDR_W-1:0] word,
  output logic              legal
);

  logic lat_ok;
  logic len_ok;
  logic page_ok;

  always_comb begin
    lat_ok  = (cfg.cas_lat == 3'd2) || (cfg.cas_lat == 3'd3);
    len_ok  = (cfg.burst_len <= 3'd3) || (cfg.burst_len == 3'd7);
    page_ok = !((cfg.burst_len == 3'd7) && cfg.burst_ilv);
    legal   = lat_ok && len_ok && page_ok;
  end

  always_comb begin
    word      = '0;
    word[2:0] = cfg.burst_len;
    word[3]   = cfg.burst_ilv;
    word[6:4] = cfg.cas_lat;
    word[8:7] = 2'b00;
    word[9]   = cfg.single_wr;
  end

endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CW      = 16,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= CW'(RST_VAL);
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int REF_COUNT = 2,
  parameter bit MRS_FIRST = 1'b0,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int CW        = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tmr_zero,
  input  logic          cfg_legal,
  output init_state_e   state,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);

  localparam int RCW = $clog2(REF_COUNT + 1);

  init_state_e    state_q, state_d;
  logic [RCW-1:0] ref_q, ref_d;
  logic           mrs_q, mrs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_STABLE;
      ref_q   <= '0;
      mrs_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
      mrs_q   <= mrs_d;
    end
  end

  always_comb begin
    state_d  = state_q;
    ref_d    = ref_q;
    mrs_d    = mrs_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_STABLE: if (tmr_zero) state_d = ST_PRE;
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(T_RP - 1);
        state_d  = ST_GAP;
      end
      ST_REF: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(T_RFC - 1);
        ref_d    = ref_q + 1'b1;
        state_d  = ST_GAP;
      end
      ST_MRS: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(T_MRD - 1);
        mrs_d    = 1'b1;
        state_d  = ST_GAP;
      end
      ST_GAP: begin
        if (tmr_zero) begin
          if (!mrs_q && (MRS_FIRST || ref_q == RCW'(REF_COUNT)))
            state_d = cfg_legal ? ST_MRS : ST_HALT;
          else if (ref_q < RCW'(REF_COUNT))
            state_d = ST_REF;
          else
            state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_DONE;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  assign state = state_q;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int STABLE_US = 200,
  parameter int REF_COUNT = 2,
  parameter bit MRS_FIRST = 1'b0,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int ADDR_W    = 13,
  parameter int DQM_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_ilv,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_single_wr,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic              init_ready,
  output logic              cfg_error
);

  localparam int WAIT_CYC = CLK_MHZ * STABLE_US;
  localparam int GAP_MAX  = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                           : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int CNT_MAX  = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
  localparam int CW       = $clog2(CNT_MAX + 1);

  generate
    if (REF_COUNT < 2) begin : g_bad_ref
      $error("REF_COUNT must be at least 2");
    end
    if (ADDR_W < MODE_BITS) begin : g_bad_addr
      $error("ADDR_W too narrow for the mode word");
    end
    if (WAIT_CYC < 1 || T_RP < 1 || T_RFC < 1 || T_MRD < 1) begin : g_bad_time
      $error("wait and recovery counts must be at least 1");
    end
  endgenerate

  mode_cfg_t         cfg;
  logic [ADDR_W-1:0] mode_word;
  logic              mode_legal;
  init_state_e       state;
  logic              tmr_load;
  logic [CW-1:0]     tmr_val;
  logic              tmr_zero;
  sdram_cmd_e        cmd;

  assign cfg = '{burst_len: cfg_burst_len, burst_ilv: cfg_burst_ilv,
                 cas_lat: cfg_cas_lat, single_wr: cfg_single_wr};

  sdram_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .cfg   (cfg),
    .word  (mode_word),
    .legal (mode_legal)
  );

  sdram_init_timer #(.CW(CW), .RST_VAL(WAIT_CYC - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sdram_init_fsm #(
    .REF_COUNT (REF_COUNT),
    .MRS_FIRST (MRS_FIRST),
    .T_RP      (T_RP),
    .T_RFC     (T_RFC),
    .T_MRD     (T_MRD),
    .CW        (CW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tmr_zero  (tmr_zero),
    .cfg_legal (mode_legal),
    .state     (state),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val)
  );

  always_comb begin
    cmd     = CMD_NOP;
    sd_addr = '0;
    unique case (state)
      ST_PRE: begin
        cmd             = CMD_PRE;
        sd_addr[AP_BIT] = 1'b1;
      end
      ST_REF: cmd = CMD_REF;
      ST_MRS: begin
        cmd     = CMD_MRS;
        sd_addr = mode_word;
      end
      default: cmd = CMD_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cke     = 1'b1;
  assign sd_dqm     = '1;
  assign sd_ba      = '0;
  assign init_ready = (state == ST_DONE);
  assign cfg_error  = (state == ST_HALT);

endmodule

// File: rtl/sdram_init_checker.sv
module sdram_init_checker #(
  parameter int ADDR_W = 13,
  parameter int DQM_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [1:0]        sd_ba,
  input logic              init_ready,
  input logic              cfg_error
);

  logic [3:0] c;
  assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  assert_cke_dqm_high_R1: assert property (@(posedge clk) disable iff (rst)
    sd_cke && (&sd_dqm));

  assert_pre_all_banks_R2: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0010) |-> sd_addr[10]);

  assert_one_cycle_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    (c != 4'b0111) |=> (c == 4'b0111));

  assert_mrs_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0000) |-> (sd_addr[12:10] == 3'b000 && sd_addr[8:7] == 2'b00 && sd_ba == 2'b00));

  assert_mrs_legal_R8: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0000) |-> ((sd_addr[6:4] == 3'd2 || sd_addr[6:4] == 3'd3) &&
                        (sd_addr[2:0] <= 3'd3 || sd_addr[2:0] == 3'd7)));

  assert_full_page_seq_R9: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0000 && sd_addr[2:0] == 3'd7) |-> !sd_addr[3]);

  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    init_ready |=> init_ready);

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    init_ready |-> (c == 4'b0111));

  assert_error_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_error |=> (cfg_error && c == 4'b0111));

  assert_error_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    !(cfg_error && init_ready));

endmodule

bind sdram_init_seq sdram_init_checker #(.ADDR_W(ADDR_W), .DQM_W(DQM_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sd_cke     (sd_cke),
  .sd_cs_n    (sd_cs_n),
  .sd_ras_n   (sd_ras_n),
  .sd_cas_n   (sd_cas_n),
  .sd_we_n    (sd_we_n),
  .sd_dqm     (sd_dqm),
  .sd_addr    (sd_addr),
  .sd_ba      (sd_ba),
  .init_ready (init_ready),
  .cfg_error  (cfg_error)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  localparam int CLK_MHZ = 1;
  localparam int STABLE_US = 20;
  localparam int W = CLK_MHZ * STABLE_US;
  localparam int NREF = 3;
  localparam int TRP = 2;
  localparam int TRFC = 4;
  localparam int TMRD = 3;

  typedef struct {
    logic [3:0]  cmd;
    logic [12:0] addr;
    logic        rdy;
    logic        err;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bl = 3'd0;
  logic       bt = 1'b0;
  logic [2:0] cl = 3'd2;
  logic       wbm = 1'b0;

  logic        cke0, cs0, ras0, cas0, we0, rdy0, err0;
  logic [1:0]  dqm0, ba0;
  logic [12:0] addr0;
  logic        cke1, cs1, ras1, cas1, we1, rdy1, err1;
  logic [1:0]  dqm1, ba1;
  logic [12:0] addr1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  exp_t q0[$];
  exp_t q1[$];
  exp_t tail0, tail1;

  always #5 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .REF_COUNT(NREF), .MRS_FIRST(1'b0),
    .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .ADDR_W(13), .DQM_W(2)
  ) u_sdram_init_seq (
    .clk(clk), .rst(rst), .cfg_burst_len(bl), .cfg_burst_ilv(bt), .cfg_cas_lat(cl),
    .cfg_single_wr(wbm), .sd_cke(cke0), .sd_cs_n(cs0), .sd_ras_n(ras0), .sd_cas_n(cas0),
    .sd_we_n(we0), .sd_dqm(dqm0), .sd_addr(addr0), .sd_ba(ba0), .init_ready(rdy0),
    .cfg_error(err0)
  );

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .REF_COUNT(NREF), .MRS_FIRST(1'b1),
    .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .ADDR_W(13), .DQM_W(2)
  ) u_sdram_init_seq_mf (
    .clk(clk), .rst(rst), .cfg_burst_len(bl), .cfg_burst_ilv(bt), .cfg_cas_lat(cl),
    .cfg_single_wr(wbm), .sd_cke(cke1), .sd_cs_n(cs1), .sd_ras_n(ras1), .sd_cas_n(cas1),
    .sd_we_n(we1), .sd_dqm(dqm1), .sd_addr(addr1), .sd_ba(ba1), .init_ready(rdy1),
    .cfg_error(err1)
  );

  function automatic exp_t mk(logic [3:0] c, logic [12:0] a, logic r, logic e, string t);
    exp_t x;
    x.cmd = c; x.addr = a; x.rdy = r; x.err = e; x.tag = t;
    return x;
  endfunction

  task automatic push(int w, exp_t e);
    if (w == 0) q0.push_back(e); else q1.push_back(e);
  endtask

  task automatic push_nops(int w, int n, string t);
    for (int i = 0; i < n; i++) push(w, mk(4'b0111, 13'd0, 1'b0, 1'b0, t));
  endtask

  // Expected timeline per R1..R9; entry j is the output after rising edge j+1.
  task automatic build(int w, bit mf, bit legal, logic [12:0] mw);
    exp_t t;
    push_nops(w, W - 1, "R1");
    push(w, mk(4'b0010, 13'h0400, 1'b0, 1'b0, "R2"));
    push_nops(w, TRP, "R6");
    if (mf) begin
      if (!legal) begin
        t = mk(4'b0111, 13'd0, 1'b0, 1'b1, "R8");
      end else begin
        push(w, mk(4'b0000, mw, 1'b0, 1'b0, "R4/R5"));
        push_nops(w, TMRD, "R6");
        for (int r = 0; r < NREF; r++) begin
          push(w, mk(4'b0001, 13'd0, 1'b0, 1'b0, "R3"));
          push_nops(w, TRFC, "R3");
        end
        t = mk(4'b0111, 13'd0, 1'b1, 1'b0, "R7");
      end
    end else begin
      for (int r = 0; r < NREF; r++) begin
        push(w, mk(4'b0001, 13'd0, 1'b0, 1'b0, "R3"));
        push_nops(w, TRFC, "R3");
      end
      if (!legal) begin
        t = mk(4'b0111, 13'd0, 1'b0, 1'b1, "R8");
      end else begin
        push(w, mk(4'b0000, mw, 1'b0, 1'b0, "R4/R5"));
        push_nops(w, TMRD, "R6");
        t = mk(4'b0111, 13'd0, 1'b1, 1'b0, "R7");
      end
    end
    if (w == 0) tail0 = t; else tail1 = t;
  endtask

  task automatic compare(int w, exp_t e, string ctx);
    logic [3:0] c; logic [12:0] a; logic [1:0] b; logic [1:0] d; logic k, r, er;
    if (w == 0) begin
      c = {cs0, ras0, cas0, we0}; a = addr0; b = ba0; d = dqm0; k = cke0; r = rdy0; er = err0;
    end else begin
      c = {cs1, ras1, cas1, we1}; a = addr1; b = ba1; d = dqm1; k = cke1; r = rdy1; er = err1;
    end
    checks++;
    if (c !== e.cmd || a !== e.addr || b !== 2'b00 || d !== 2'b11 || k !== 1'b1 ||
        r !== e.rdy || er !== e.err) begin
      errors++;
      $display("FAIL %s %s inst%0d t=%0t: act cmd=%b addr=%h ba=%b dqm=%b cke=%b rdy=%b err=%b exp cmd=%b addr=%h ba=00 dqm=11 cke=1 rdy=%b err=%b",
               e.tag, ctx, w, $time, c, a, b, d, k, r, er, e.cmd, e.addr, e.rdy, e.err);
    end
  endtask

  task automatic run(logic [2:0] l, logic t, logic [2:0] lat, logic s, int ncyc, string ctx);
    bit legal;
    logic [12:0] mw;
    exp_t idle;
    legal = ((lat == 3'd2) || (lat == 3'd3)) && ((l <= 3'd3) || (l == 3'd7)) && !(l == 3'd7 && t);
    mw = (13'(s) << 9) | (13'(lat) << 4) | (13'(t) << 3) | 13'(l);
    q0.delete(); q1.delete();
    build(0, 1'b0, legal, mw);
    build(1, 1'b1, legal, mw);
    idle = mk(4'b0111, 13'd0, 1'b0, 1'b0, "R1");
    @(negedge clk);
    rst = 1'b1; bl = l; bt = t; cl = lat; wbm = s;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare(0, idle, {ctx, " reset"});
      compare(1, idle, {ctx, " reset"});
    end
    rst = 1'b0;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      compare(0, (k - 1 < q0.size()) ? q0[k - 1] : tail0, ctx);
      compare(1, (k - 1 < q1.size()) ? q1[k - 1] : tail1, ctx);
    end
  endtask

  initial begin
    fork
      begin
        // R5 burst 8 sequential CL2
        run(3'd3, 1'b0, 3'd2, 1'b0, 70, "bl8 seq cl2");
        // R10 reset in mid-sequence, then full restart
        run(3'd1, 1'b1, 3'd3, 1'b1, 30, "partial");
        run(3'd1, 1'b1, 3'd3, 1'b1, 70, "R10 restart bl2 ilv cl3");
        // R9 full page sequential is legal
        run(3'd7, 1'b0, 3'd3, 1'b1, 70, "R9 full page seq");
        // R9 full page interleaved is refused
        run(3'd7, 1'b1, 3'd2, 1'b0, 70, "R9 full page ilv");
        // R8 reserved latency and reserved burst code
        run(3'd2, 1'b0, 3'd4, 1'b0, 70, "R8 cl4");
        run(3'd5, 1'b0, 3'd2, 1'b0, 70, "R8 bl5");
        run(3'd0, 1'b1, 3'd2, 1'b1, 70, "bl1 ilv cl2");
      end
      begin
        while (cycles < 100000) begin
          @(posedge clk);
          cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: act cycles=%0d exp finish earlier", cycles);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule